// File: doc/BRIEF.md
# Sponge AEAD Mode Sequencer

This block sequences a sponge-style authenticated-encryption mode around a 256-bit state. The state splits into a 64-bit rate and a 192-bit capacity. The key, the nonce and the tag are each 128 bits. A transaction starts with a one-cycle `start` pulse, which also latches the key, the nonce, the direction and the lengths of the associated data and of the message.

The sequencer then walks through five steps:
1. It seeds the state and runs an initial permutation.
2. It absorbs the associated data, one byte per handshake on a byte-wide input stream.
3. It marks the change of domain.
4. It encrypts or decrypts the message bytes.
5. It finalizes the state, then either streams the tag out or checks a received tag.

The permutation itself sits outside the block. The sequencer hands it the whole state and a round count over a request/done handshake, and takes the result back on done. One rate-block engine serves every phase, and only the round count changes: 52, 28 or 32.

When encrypting, the output stream carries the ciphertext bytes and then the 16 tag bytes. When decrypting, the input stream carries the ciphertext and then the 16 received tag bytes. The recovered plaintext waits in an internal buffer and leaves only if every tag byte matches.

Top module: `aead_seq`

## Requirements
- R1: On `start`, the first permutation request carries nonce byte i in state byte i for i = 0..15 and key byte i in state byte 16+i, with a round count of 52. State byte i is bits [8i+7:8i]; key and nonce byte i is bits [8i+7:8i] of those ports.
- R2: Associated data is absorbed into state bytes 0..7 in arrival order. Each complete group of 8 bytes is followed by a 28-round permutation.
- R3: After the last associated-data byte, 0x01 is XORed into the next rate byte position, and a 28-round permutation follows. When the length is a multiple of 8, this is a block of padding alone, with 0x01 in byte 0.
- R4: A zero associated-data length adds no padding and requests no permutation beyond the initial one.
- R5: 0x80 is XORed into state byte 31 once the associated-data phase ends, whether or not any associated data was present.
- R6: When encrypting, each output byte is the message byte XOR the current rate byte, and that rate byte takes the ciphertext value.
- R7: When decrypting, each recovered byte is the ciphertext byte XOR the current rate byte, and that rate byte takes the ciphertext value.
- R8: Each full 8-byte message block is followed by a 28-round permutation. The final 0..7 bytes are padded with 0x01 and not permuted. A zero message length adds no padding.
- R9: Finalization requests 32 rounds. When encrypting, state bytes 0..15 then leave as the tag, directly after the ciphertext.
- R10: When decrypting, the 16 received tag bytes are compared with state bytes 0..15. On a match `tag_status` becomes 0x00 and the plaintext is released in order. On any difference `tag_status` becomes 0xFF and no plaintext is released.
- R11: `ct_len` reports the message length plus 16 from the cycle after `start`.
- R12: While a permutation request is pending, it stays asserted and no input or output byte is accepted or offered.
- R13: `done` is a single-cycle pulse at the end of every transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transaction (accepted while idle) |
| decrypt | input | 1 | 1 = decrypt and verify, 0 = encrypt |
| key | input | 128 | Secret key, byte i at bits [8i+7:8i] |
| nonce | input | 128 | Public nonce, byte i at bits [8i+7:8i] |
| ad_len | input | LEN_W | Associated-data length in bytes |
| msg_len | input | LEN_W | Message length in bytes (at most MAX_MSG) |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte: associated data, then message or ciphertext, then tag when decrypting |
| in_ready | output | 1 | Input byte accepted when high together with in_valid |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Ciphertext and tag, or released plaintext |
| out_ready | input | 1 | Sink takes the output byte |
| perm_req | output | 1 | Permutation request, held until perm_done |
| perm_rounds | output | 8 | Round count for the pending request |
| perm_state_o | output | 256 | State handed to the permutation |
| perm_done | input | 1 | Permutation result valid |
| perm_state_i | input | 256 | Permuted state |
| done | output | 1 | End-of-transaction pulse |
| tag_status | output | 8 | 0x00 tag accepted, 0xFF tag rejected |
| ct_len | output | LEN_W+1 | Message length plus 16 |

## Verification
The bound checker watches the permutation handshake on every cycle. A request must stay up until done, must carry one of the three legal round counts, and must silence both byte streams while it is pending. The checker also requires `done` to be a lone pulse and `tag_status` to hold a legal code whenever `done` fires. Correct padding positions, the domain bit, the order of the permutation inputs, the tag bytes and the release or withholding of plaintext only show up in the bench's end-to-end scenarios. Those scenarios compare every permutation input and every output byte against a reference model, for empty, block-aligned and ragged lengths, in both directions, with good and corrupted tags.

// File: rtl/aead_seq_pkg.sv
package aead_seq_pkg;

    localparam int STATE_BYTES = 32;
    localparam int RATE_BYTES  = 8;
    localparam int KEY_BYTES   = 16;
    localparam int NONCE_BYTES = 16;
    localparam int TAG_BYTES   = 16;
    localparam int STATE_W     = STATE_BYTES * 8;
    localparam int IDX_W       = $clog2(STATE_BYTES);

    localparam logic [7:0] ROUNDS_INIT = 8'd52;
    localparam logic [7:0] ROUNDS_MID  = 8'd28;
    localparam logic [7:0] ROUNDS_FIN  = 8'd32;
    localparam logic [7:0] PAD_BYTE    = 8'h01;
    localparam logic [7:0] DOMAIN_BYTE = 8'h80;
    localparam logic [7:0] TAG_BAD     = 8'hFF;
    localparam logic [7:0] TAG_GOOD    = 8'h00;

    typedef logic [STATE_W-1:0] state_t;
    typedef logic [IDX_W-1:0]   idx_t;

    typedef enum logic [3:0] {
        PH_IDLE, PH_PERM, PH_AD, PH_DOM, PH_MSG,
        PH_FIN, PH_TAG, PH_CHECK, PH_FLUSH, PH_DONE
    } phase_e;

    function automatic logic [7:0] byte_at(input state_t s, input idx_t i);
        return s[8*i +: 8];
    endfunction

    function automatic logic last_rate_byte(input idx_t i);
        return i == idx_t'(RATE_BYTES - 1);
    endfunction

    function automatic logic last_tag_byte(input idx_t i);
        return i == idx_t'(TAG_BYTES - 1);
    endfunction

endpackage

// File: rtl/aead_plain_buf.sv
module aead_plain_buf #(
    parameter int DEPTH = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       rd_en,
    output logic [7:0] rd_data
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wptr, rptr;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (wr_en) wptr <= wptr + 1'b1;
            if (rd_en) rptr <= rptr + 1'b1;
        end
    end

    assign rd_data = mem[rptr];
endmodule

// File: rtl/aead_tag_cmp.sv
module aead_tag_cmp (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       en,
    input  logic [7:0] calc,
    input  logic [7:0] recv,
    output logic       differ
);
    always_ff @(posedge clk) begin
        if (rst || clear)          differ <= 1'b0;
        else if (en && calc != recv) differ <= 1'b1;
    end
endmodule

// File: rtl/aead_seq.sv
module aead_seq
    import aead_seq_pkg::*;
#(
    parameter int LEN_W   = 7,
    parameter int MAX_MSG = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               decrypt,
    input  logic [127:0]       key,
    input  logic [127:0]       nonce,
    input  logic [LEN_W-1:0]   ad_len,
    input  logic [LEN_W-1:0]   msg_len,
    input  logic               in_valid,
    input  logic [7:0]         in_data,
    output logic               in_ready,
    output logic               out_valid,
    output logic [7:0]         out_data,
    input  logic               out_ready,
    output logic               perm_req,
    output logic [7:0]         perm_rounds,
    output logic [255:0]       perm_state_o,
    input  logic               perm_done,
    input  logic [255:0]       perm_state_i,
    output logic               done,
    output logic [7:0]         tag_status,
    output logic [LEN_W:0]     ct_len
);
    phase_e           phase, ret_phase;
    state_t           st;
    idx_t             idx;
    logic             dec_q;
    logic [7:0]       rounds_q, status_q;
    logic [LEN_W-1:0] ad_rem, msg_rem, len_q, flush_cnt;
    logic [LEN_W:0]   ctlen_q;
    logic [7:0]       cur_byte, buf_rdata;
    logic             in_fire, out_fire, differ, clear_q;
    logic             buf_wr, buf_rd, cmp_en;

    assign cur_byte = byte_at(st, idx);

    always_comb begin
        in_ready = 1'b0;
        unique case (phase)
            PH_AD:  in_ready = ad_rem != '0;
            PH_MSG: in_ready = (msg_rem != '0) && (dec_q || out_ready);
            PH_TAG: in_ready = dec_q;
            default: in_ready = 1'b0;
        endcase
    end

    always_comb begin
        out_valid = 1'b0;
        out_data  = cur_byte;
        if (phase == PH_MSG && !dec_q && msg_rem != '0) begin
            out_valid = in_valid;
            out_data  = in_data ^ cur_byte;
        end else if (phase == PH_TAG && !dec_q) begin
            out_valid = 1'b1;
        end else if (phase == PH_FLUSH) begin
            out_valid = 1'b1;
            out_data  = buf_rdata;
        end
    end

    assign in_fire  = in_valid && in_ready;
    assign out_fire = out_valid && out_ready;
    assign buf_wr   = (phase == PH_MSG) && dec_q && in_fire;
    assign buf_rd   = (phase == PH_FLUSH) && out_fire;
    assign cmp_en   = (phase == PH_TAG) && dec_q && in_fire;

    aead_plain_buf #(.DEPTH(MAX_MSG)) i_buf (
        .clk(clk), .rst(rst), .clear(clear_q),
        .wr_en(buf_wr), .wr_data(in_data ^ cur_byte),
        .rd_en(buf_rd), .rd_data(buf_rdata)
    );

    aead_tag_cmp i_cmp (
        .clk(clk), .rst(rst), .clear(clear_q),
        .en(cmp_en), .calc(cur_byte), .recv(in_data),
        .differ(differ)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_IDLE;
            ret_phase <= PH_IDLE;
            st        <= '0;
            idx       <= '0;
            dec_q     <= 1'b0;
            rounds_q  <= ROUNDS_INIT;
            status_q  <= TAG_GOOD;
            ad_rem    <= '0;
            msg_rem   <= '0;
            len_q     <= '0;
            flush_cnt <= '0;
            ctlen_q   <= '0;
            clear_q   <= 1'b0;
        end else begin
            clear_q <= 1'b0;
            unique case (phase)
                PH_IDLE: if (start) begin
                    st        <= {key, nonce};
                    dec_q     <= decrypt;
                    ad_rem    <= ad_len;
                    msg_rem   <= msg_len;
                    len_q     <= msg_len;
                    ctlen_q   <= {1'b0, msg_len} + (LEN_W+1)'(TAG_BYTES);
                    rounds_q  <= ROUNDS_INIT;
                    ret_phase <= (ad_len == '0) ? PH_DOM : PH_AD;
                    status_q  <= TAG_GOOD;
                    clear_q   <= 1'b1;
                    phase     <= PH_PERM;
                end
                PH_PERM: if (perm_done) begin
                    st    <= perm_state_i;
                    idx   <= '0;
                    phase <= ret_phase;
                end
                PH_AD: begin
                    if (ad_rem == '0) begin
                        st[8*idx +: 8] <= cur_byte ^ PAD_BYTE;
                        rounds_q  <= ROUNDS_MID;
                        ret_phase <= PH_DOM;
                        phase     <= PH_PERM;
                    end else if (in_fire) begin
                        st[8*idx +: 8] <= cur_byte ^ in_data;
                        ad_rem <= ad_rem - 1'b1;
                        if (last_rate_byte(idx)) begin
                            rounds_q  <= ROUNDS_MID;
                            ret_phase <= PH_AD;
                            phase     <= PH_PERM;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                PH_DOM: begin
                    st[STATE_W-1 -: 8] <= st[STATE_W-1 -: 8] ^ DOMAIN_BYTE;
                    idx   <= '0;
                    phase <= (msg_rem == '0) ? PH_FIN : PH_MSG;
                end
                PH_MSG: begin
                    if (msg_rem == '0) begin
                        st[8*idx +: 8] <= cur_byte ^ PAD_BYTE;
                        phase <= PH_FIN;
                    end else if (in_fire) begin
                        st[8*idx +: 8] <= dec_q ? in_data : (in_data ^ cur_byte);
                        msg_rem <= msg_rem - 1'b1;
                        if (last_rate_byte(idx)) begin
                            rounds_q  <= ROUNDS_MID;
                            ret_phase <= PH_MSG;
                            phase     <= PH_PERM;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                PH_FIN: begin
                    rounds_q  <= ROUNDS_FIN;
                    ret_phase <= PH_TAG;
                    phase     <= PH_PERM;
                end
                PH_TAG: if ((dec_q && in_fire) || (!dec_q && out_fire)) begin
                    idx <= idx + 1'b1;
                    if (last_tag_byte(idx)) phase <= dec_q ? PH_CHECK : PH_DONE;
                end
                PH_CHECK: begin
                    status_q  <= differ ? TAG_BAD : TAG_GOOD;
                    flush_cnt <= '0;
                    phase     <= (differ || len_q == '0) ? PH_DONE : PH_FLUSH;
                end
                PH_FLUSH: if (out_fire) begin
                    flush_cnt <= flush_cnt + 1'b1;
                    if (flush_cnt == len_q - 1'b1) phase <= PH_DONE;
                end
                PH_DONE: phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign perm_req     = phase == PH_PERM;
    assign perm_rounds  = rounds_q;
    assign perm_state_o = st;
    assign done         = phase == PH_DONE;
    assign tag_status   = status_q;
    assign ct_len       = ctlen_q;
endmodule

// File: rtl/aead_seq_chk.sv
module aead_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       perm_req,
    input logic       perm_done,
    input logic [7:0] perm_rounds,
    input logic       in_ready,
    input logic       out_valid,
    input logic       done,
    input logic [7:0] tag_status
);
    // R12: a pending request is held until the permutation answers
    p_req_held_r12: assert property (@(posedge clk) disable iff (rst)
        perm_req && !perm_done |=> perm_req);

    // R12: both byte streams are quiet while the permutation runs
    p_quiet_in_perm_r12: assert property (@(posedge clk) disable iff (rst)
        perm_req |-> !in_ready && !out_valid);

    // R1, R2, R9: only the three phase round counts are ever requested
    p_rounds_legal_r9: assert property (@(posedge clk) disable iff (rst)
        perm_req |-> (perm_rounds == 8'd52 || perm_rounds == 8'd28 || perm_rounds == 8'd32));

    // R13: completion lasts exactly one cycle
    p_done_single_r13: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10: the verdict is one of the two legal codes at completion
    p_status_code_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> (tag_status == 8'h00 || tag_status == 8'hFF));
endmodule

bind aead_seq aead_seq_chk i_aead_seq_chk (
    .clk(clk), .rst(rst), .perm_req(perm_req), .perm_done(perm_done),
    .perm_rounds(perm_rounds), .in_ready(in_ready), .out_valid(out_valid),
    .done(done), .tag_status(tag_status)
);

// File: tb/test_aead_seq.sv
module test_aead_seq;
    localparam int LEN_W = 7;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0, decrypt = 1'b0;
    logic [127:0] key = '0, nonce = '0;
    logic [LEN_W-1:0] ad_len = '0, msg_len = '0;
    logic in_valid = 1'b0, out_ready = 1'b0, perm_done = 1'b0;
    logic [7:0] in_data = '0;
    logic [255:0] perm_state_i = '0;
    logic in_ready, out_valid, perm_req, done;
    logic [7:0] out_data, perm_rounds, tag_status;
    logic [255:0] perm_state_o;
    logic [LEN_W:0] ct_len;

    int checks = 0, fails = 0;

    always #10 clk = ~clk;

    aead_seq #(.LEN_W(LEN_W), .MAX_MSG(64)) i_aead_seq (
        .clk(clk), .rst(rst), .start(start), .decrypt(decrypt), .key(key), .nonce(nonce),
        .ad_len(ad_len), .msg_len(msg_len), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .perm_req(perm_req), .perm_rounds(perm_rounds), .perm_state_o(perm_state_o),
        .perm_done(perm_done), .perm_state_i(perm_state_i), .done(done),
        .tag_status(tag_status), .ct_len(ct_len)
    );

    function automatic logic [255:0] stand_in(input logic [255:0] s, input logic [7:0] r);
        return {s[254:0], s[255]} ^ {248'b0, r};
    endfunction

    // stimulus and model storage
    logic [7:0] ad_b [64];
    logic [7:0] msg_b [64];
    logic [7:0] din_b [64];
    logic [7:0] mout_b [64];
    logic [7:0] mtag [16];
    logic [7:0] exp_r [32];
    logic [255:0] exp_s [32];
    int exp_n;

    // observed
    logic [7:0] got_r [32];
    logic [255:0] got_s [32];
    int got_n = 0;
    logic [7:0] got_o [96];
    int got_on = 0;
    logic done_seen = 1'b0;
    logic prev_done = 1'b0;

    function automatic void check(input bit ok, input string req, input string what,
                                  input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endfunction

    task automatic model(input bit dec, input int al, input int ml);
        logic [255:0] s;
        int pos;
        logic [7:0] c;
        exp_n = 0;
        s = {key, nonce};
        exp_r[exp_n] = 8'd52; exp_s[exp_n] = s; exp_n++; s = stand_in(s, 8'd52);
        if (al > 0) begin
            pos = 0;
            for (int k = 0; k < al; k++) begin
                s[8*pos +: 8] ^= ad_b[k]; pos++;
                if (pos == 8) begin
                    exp_r[exp_n] = 8'd28; exp_s[exp_n] = s; exp_n++; s = stand_in(s, 8'd28); pos = 0;
                end
            end
            s[8*pos +: 8] ^= 8'h01;
            exp_r[exp_n] = 8'd28; exp_s[exp_n] = s; exp_n++; s = stand_in(s, 8'd28);
        end
        s[255:248] ^= 8'h80;
        if (ml > 0) begin
            pos = 0;
            for (int k = 0; k < ml; k++) begin
                c = din_b[k] ^ s[8*pos +: 8];
                mout_b[k] = c;
                s[8*pos +: 8] = dec ? din_b[k] : c; pos++;
                if (pos == 8) begin
                    exp_r[exp_n] = 8'd28; exp_s[exp_n] = s; exp_n++; s = stand_in(s, 8'd28); pos = 0;
                end
            end
            s[8*pos +: 8] ^= 8'h01;
        end
        exp_r[exp_n] = 8'd32; exp_s[exp_n] = s; exp_n++; s = stand_in(s, 8'd32);
        for (int k = 0; k < 16; k++) mtag[k] = s[8*k +: 8];
    endtask

    // permutation stand-in, driven on the falling edge
    logic [255:0] hold_s;
    logic [7:0] hold_r;
    logic pbusy = 1'b0;
    int pcnt = 0;
    always @(negedge clk) begin
        if (perm_done) perm_done = 1'b0;
        else if (pbusy) begin
            if (pcnt == 0) begin
                perm_state_i = stand_in(hold_s, hold_r);
                perm_done = 1'b1; pbusy = 1'b0;
            end else pcnt--;
        end else if (perm_req && !rst) begin
            if (got_n < 32) begin
                got_r[got_n] = perm_rounds; got_s[got_n] = perm_state_o;
            end
            got_n++;
            hold_s = perm_state_o; hold_r = perm_rounds;
            pbusy = 1'b1; pcnt = $urandom % 3;
        end
    end

    // output sink and per-cycle observations
    initial begin
        forever begin
            @(negedge clk);
            out_ready = ($urandom % 4) != 0;
            #9;
            if (!rst) begin
                if (out_valid && out_ready) begin
                    if (got_on < 96) got_o[got_on] = out_data;
                    got_on++;
                end
                if (perm_req && (in_ready || out_valid))
                    check(0, "R12", "stream active during permutation", 1, 0);
                if (done && prev_done) check(0, "R13", "done longer than one cycle", 2, 1);
                if (done) done_seen = 1'b1;
                prev_done = done;
            end
        end
    end

    task automatic send(input logic [7:0] b);
        bit acc = 0;
        in_valid = 1'b1; in_data = b;
        while (!acc) begin
            #9; acc = in_ready;
            @(negedge clk);
        end
        in_valid = 1'b0;
        repeat ($urandom % 2) @(negedge clk);
    endtask

    task automatic run_case(input bit dec, input int al, input int ml, input bit corrupt);
        logic [7:0] enc_tag [16];
        logic [7:0] ct [64];
        int eo_n;
        bit ok;
        key = {$urandom, $urandom, $urandom, $urandom};
        nonce = {$urandom, $urandom, $urandom, $urandom};
        for (int k = 0; k < al; k++) ad_b[k] = 8'($urandom);
        for (int k = 0; k < ml; k++) begin msg_b[k] = 8'($urandom); din_b[k] = msg_b[k]; end
        model(1'b0, al, ml);
        for (int k = 0; k < 16; k++) enc_tag[k] = mtag[k];
        for (int k = 0; k < ml; k++) ct[k] = mout_b[k];
        if (dec) begin
            for (int k = 0; k < ml; k++) din_b[k] = ct[k];
            model(1'b1, al, ml);
        end
        got_n = 0; got_on = 0; done_seen = 1'b0;
        @(negedge clk);
        start = 1'b1; decrypt = dec; ad_len = LEN_W'(al); msg_len = LEN_W'(ml);
        @(negedge clk);
        start = 1'b0;
        #9;
        check(ct_len == (LEN_W+1)'(ml + 16), "R11", "ct_len", ct_len, ml + 16);
        @(negedge clk);
        for (int k = 0; k < al; k++) send(ad_b[k]);
        for (int k = 0; k < ml; k++) send(din_b[k]);
        if (dec) for (int k = 0; k < 16; k++) send((corrupt && k == 5) ? (enc_tag[k] ^ 8'h10) : enc_tag[k]);
        while (!done_seen) @(negedge clk);
        @(negedge clk);
        // permutation requests: round counts and handed-over states
        check(got_n == exp_n, "R4 R8", "permutation count", got_n, exp_n);
        ok = 1;
        for (int k = 0; k < exp_n && k < got_n; k++) if (got_r[k] != exp_r[k]) ok = 0;
        check(ok, "R1 R2 R9", "round count sequence", got_r[got_n > 0 ? got_n-1 : 0], exp_r[exp_n-1]);
        check(got_n > 0 && got_s[0] == {key, nonce}, "R1", "initial state",
              got_s[0][63:0], nonce[63:0]);
        ok = 1;
        for (int k = 0; k < exp_n && k < got_n; k++) if (got_s[k] != exp_s[k]) ok = 0;
        check(ok, "R2 R3 R5 R8", "permutation input states", got_n, exp_n);
        // output stream
        eo_n = dec ? (corrupt ? 0 : ml) : ml + 16;
        check(got_on == eo_n, dec ? "R10" : "R9", "output byte count", got_on, eo_n);
        ok = 1;
        for (int k = 0; k < eo_n && k < got_on; k++) begin
            logic [7:0] e;
            e = dec ? msg_b[k] : (k < ml ? ct[k] : enc_tag[k-ml]);
            if (got_o[k] != e) begin
                if (ok) check(0, dec ? "R7" : "R6 R9", "output byte", got_o[k], e);
                ok = 0;
            end
        end
        if (ok) check(1, "R6 R7", "output bytes", 0, 0);
        check(tag_status == ((dec && corrupt) ? 8'hFF : 8'h00), "R10", "tag status",
              tag_status, (dec && corrupt) ? 8'hFF : 8'h00);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #9;
        check(!in_ready && !out_valid && !perm_req && !done && tag_status == 8'h00,
              "R13", "reset state", {in_ready, out_valid, perm_req, done}, 0);
        @(negedge clk);
        run_case(1'b0, 0, 0, 1'b0);   // R4: empty everything
        run_case(1'b0, 8, 8, 1'b0);   // R3 R8: aligned lengths
        run_case(1'b0, 3, 13, 1'b0);  // ragged lengths
        run_case(1'b1, 5, 16, 1'b0);  // R7 R10: good tag
        run_case(1'b1, 7, 9, 1'b1);   // R10: bad tag withholds plaintext
        run_case(1'b1, 0, 0, 1'b0);   // empty decrypt
        run_case(1'b0, 16, 0, 1'b0);  // R8: empty message, padding-only AD block
        for (int n = 0; n < 8; n++)
            run_case(1'($urandom), int'($urandom % 41), int'($urandom % 41), 1'($urandom));
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule